// File: doc/BRIEF.md
# PCI target cycle controller

This block is the target side of a 32-bit PCI bus interface for a single-function peripheral. It watches the bus for the start of a transaction. On the address clock it latches the address and command. It claims the cycle only when the address lies inside a programmable window and the command is a memory read or a memory write. For a claimed cycle it drives device select, target ready and stop. Read data goes out on the address/data lines, with even parity one clock later. Each completed data phase is passed to a back end through a combinational address/data/acknowledge port. The back end can ask the controller to end a burst, and a mode input selects how the cycle ends.

Every shared bus output is a sustained tri-state line, modelled as a value plus an output enable. At the end of a cycle the controls are driven high for one clock and then released. On the rising edge of the reset input, mode strap pins and a swap strap pin are captured into a configuration word.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: On a clock where FRAME# is sampled low while the controller is idle, it latches AD and C/BE#[3:0]. The cycle is claimed when `((ad ^ base_i) & mask_i) == 0` and the command is 4'b0110 (memory read) or 4'b0111 (memory write). A claimed cycle drives DEVSEL# low from that edge onward.
- R2: A data phase completes only on a clock where IRDY# and TRDY# are both low. In that clock `be_ack_o` is high and `be_addr_o` already shows the next address (current + 4). Outside a claimed cycle, `be_addr_o` holds the current address.
- R3: DEVSEL# stays low until the clock on which the cycle ends (FRAME# high and the final IRDY# handshake with TRDY# or STOP#). It is then driven high for exactly one clock and then released.
- R4: TRDY# is asserted on the clock after `be_ready_i` is sampled high. Once low, it stays low until a data phase completes. It is released like DEVSEL#.
- R5: Disconnect (`retry_i`=0). With `term_req_i` high, STOP# is asserted on the same clock as TRDY#, and no further TRDY# follows that transfer.
- R6: Retry (`retry_i`=1). With `term_req_i` high, STOP# is asserted while TRDY# stays high for the rest of the cycle.
- R7: Once low, STOP# stays low until the cycle ends, then is driven high for one clock and released.
- R8: AD is driven only during claimed reads. It is driven from the second data clock until the end, with the `be_rdata_i` word for the address of the pending data phase.
- R9: PAR is driven one clock after AD is driven, and is released one clock after AD. PAR equals the XOR of AD[31:0] and C/BE#[3:0] from the previous clock, which gives even parity.
- R10: For an unclaimed cycle (address outside the window, or any other command), every target output stays released until FRAME# and IRDY# are both high.
- R11: On the rising edge of `rst_ni`, `strap_o` captures `{strap_swap_i, strap_mode_i}`. Later changes to the strap inputs have no effect.
- R12: While `rst_ni` is low, every output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_ni | input | 1 | FRAME#, cycle framing |
| irdy_ni | input | 1 | IRDY#, initiator ready |
| ad_i | input | 32 | AD bus as sampled |
| cbe_ni | input | 4 | C/BE#, command or byte enables |
| base_i | input | 32 | Window base address |
| mask_i | input | 32 | Window compare mask |
| retry_i | input | 1 | 1 = retry termination, 0 = disconnect |
| term_req_i | input | 1 | Back end asks to end the cycle |
| be_ready_i | input | 1 | Back end can complete the next data phase |
| be_rdata_i | input | 32 | Read word for `be_addr_o` |
| strap_mode_i | input | 18 | Mode strap pins |
| strap_swap_i | input | 1 | Swap strap pin |
| devsel_no | output | 1 | DEVSEL# value |
| devsel_oe_o | output | 1 | DEVSEL# drive enable |
| trdy_no | output | 1 | TRDY# value |
| trdy_oe_o | output | 1 | TRDY# drive enable |
| stop_no | output | 1 | STOP# value |
| stop_oe_o | output | 1 | STOP# drive enable |
| ad_o | output | 32 | AD read data |
| ad_oe_o | output | 1 | AD drive enable |
| par_o | output | 1 | PAR value |
| par_oe_o | output | 1 | PAR drive enable |
| be_addr_o | output | 32 | Back-end word address |
| be_we_o | output | 1 | Cycle is a write |
| be_wdata_o | output | 32 | Write data (AD) |
| be_strb_o | output | 4 | Active-high byte enables |
| be_ack_o | output | 1 | Data phase completes this clock |
| strap_o | output | 19 | Captured strap word |

## Verification
The master is driven through single writes, zero-wait and wait-stated read bursts, and write bursts whose back-end ready has gaps. Together these separate the rule that TRDY# follows ready from the rule that TRDY# holds while IRDY# is high. Disconnect and retry runs with the termination request raised at different transfer counts show whether STOP# pairs with TRDY# or replaces it. Claims are tested with an address just past the window and with a non-memory command inside the window, which checks that the window compare and the command decode are both needed. Every clock, the outputs are compared with a behavioural model. That includes parity against the previous clock's AD and C/BE#, and the one-clock high release.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_TURN = 2'd2,
    ST_SKIP = 2'd3
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] ad_i,
  input  logic [3:0]    cmd_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] mask_i,
  output logic          hit_o,
  output logic          rd_o
);
  logic win_hit;

  assign win_hit = ((ad_i ^ base_i) & mask_i) == '0;
  assign rd_o    = cmd_i == CMD_MEM_RD;
  assign hit_o   = win_hit & (rd_o | (cmd_i == CMD_MEM_WR));
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  input  logic hit_i,
  input  logic be_ready_i,
  input  logic term_req_i,
  input  logic retry_i,
  output logic dev_o,
  output logic trdy_o,
  output logic stop_o,
  output logic oe_o,
  output logic xfer_o,
  output logic latch_o,
  output logic in_data_o,
  output logic load_o
);
  tgt_state_e state_q;
  logic trdy_q, stop_q, dev_q, oe_q;
  logic in_data, shk, fin, hold, trdy_d, stop_d;

  assign in_data = state_q == ST_DATA;
  assign xfer_o  = in_data & trdy_q & ~irdy_ni;
  assign shk     = in_data & stop_q & ~irdy_ni;
  assign fin     = frame_ni & (xfer_o | shk);
  // TRDY# may not be withdrawn before its data phase completes
  assign hold    = trdy_q & irdy_ni;

  always_comb begin
    trdy_d = trdy_q;
    stop_d = stop_q;
    if (!hold) begin
      if (stop_q) begin
        trdy_d = 1'b0;
      end else if (term_req_i) begin
        if (retry_i) begin
          stop_d = 1'b1;
          trdy_d = 1'b0;
        end else begin
          stop_d = be_ready_i;
          trdy_d = be_ready_i;
        end
      end else begin
        trdy_d = be_ready_i;
      end
    end
  end

  assign latch_o   = (state_q == ST_IDLE) & ~frame_ni;
  assign in_data_o = in_data & ~fin;
  assign load_o    = in_data & ~fin & ~hold & trdy_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      trdy_q  <= 1'b0;
      stop_q  <= 1'b0;
      dev_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!frame_ni) begin
            if (hit_i) begin
              state_q <= ST_DATA;
              dev_q   <= 1'b1;
              oe_q    <= 1'b1;
              trdy_q  <= 1'b0;
              stop_q  <= 1'b0;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (fin) begin
            state_q <= ST_TURN;
            dev_q   <= 1'b0;
            trdy_q  <= 1'b0;
            stop_q  <= 1'b0;
          end else begin
            trdy_q <= trdy_d;
            stop_q <= stop_d;
          end
        end
        ST_TURN: begin
          state_q <= ST_IDLE;
          oe_q    <= 1'b0;
        end
        ST_SKIP: begin
          if (frame_ni && irdy_ni) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dev_o  = dev_q;
  assign trdy_o = trdy_q;
  assign stop_o = stop_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/pci_tgt_dpath.sv
module pci_tgt_dpath #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          latch_i,
  input  logic          rd_i,
  input  logic          xfer_i,
  input  logic          load_i,
  input  logic          in_data_i,
  input  logic [DW-1:0] ad_i,
  input  logic [DW/8-1:0] cbe_ni,
  input  logic [DW-1:0] be_rdata_i,
  output logic [DW-1:0] be_addr_o,
  output logic          rd_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          par_o,
  output logic          par_oe_o
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  logic [DW-1:0] addr_q, ad_q;
  logic rd_q, ad_oe_q, par_q, par_oe_q;

  assign be_addr_o = xfer_i ? addr_q + STEP : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      rd_q     <= 1'b0;
      ad_q     <= '0;
      ad_oe_q  <= 1'b0;
      par_q    <= 1'b0;
      par_oe_q <= 1'b0;
    end else begin
      if (latch_i) begin
        addr_q <= ad_i;
        rd_q   <= rd_i;
      end else if (xfer_i) begin
        addr_q <= addr_q + STEP;
      end
      if (load_i && rd_q) ad_q <= be_rdata_i;
      ad_oe_q  <= in_data_i & rd_q;
      // parity trails the AD/C/BE# values it covers by one clock
      par_q    <= ^{ad_q, cbe_ni};
      par_oe_q <= ad_oe_q;
    end
  end

  assign rd_o     = rd_q;
  assign ad_o     = ad_q;
  assign ad_oe_o  = ad_oe_q;
  assign par_o    = par_q;
  assign par_oe_o = par_oe_q;
endmodule

// File: rtl/pci_tgt_strap.sv
module pci_tgt_strap #(
  parameter int W = 19
) (
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q;

  // captured on the trailing edge of reset
  always_ff @(posedge rst_ni) cfg_q <= pins_i;

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl #(
  parameter int DW      = 32,
  parameter int STRAP_W = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_ni,
  input  logic                 irdy_ni,
  input  logic [DW-1:0]        ad_i,
  input  logic [DW/8-1:0]      cbe_ni,
  input  logic [DW-1:0]        base_i,
  input  logic [DW-1:0]        mask_i,
  input  logic                 retry_i,
  input  logic                 term_req_i,
  input  logic                 be_ready_i,
  input  logic [DW-1:0]        be_rdata_i,
  input  logic [STRAP_W-1:0]   strap_mode_i,
  input  logic                 strap_swap_i,
  output logic                 devsel_no,
  output logic                 devsel_oe_o,
  output logic                 trdy_no,
  output logic                 trdy_oe_o,
  output logic                 stop_no,
  output logic                 stop_oe_o,
  output logic [DW-1:0]        ad_o,
  output logic                 ad_oe_o,
  output logic                 par_o,
  output logic                 par_oe_o,
  output logic [DW-1:0]        be_addr_o,
  output logic                 be_we_o,
  output logic [DW-1:0]        be_wdata_o,
  output logic [DW/8-1:0]      be_strb_o,
  output logic                 be_ack_o,
  output logic [STRAP_W:0]     strap_o
);
  logic hit, dec_rd, dev, trdy, stop, oe, xfer, latch, in_data, load, rd_q;

  pci_tgt_decode #(.DW(DW)) u_dec (
    .ad_i   (ad_i),
    .cmd_i  (cbe_ni[3:0]),
    .base_i (base_i),
    .mask_i (mask_i),
    .hit_o  (hit),
    .rd_o   (dec_rd)
  );

  pci_tgt_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ni   (frame_ni),
    .irdy_ni    (irdy_ni),
    .hit_i      (hit),
    .be_ready_i (be_ready_i),
    .term_req_i (term_req_i),
    .retry_i    (retry_i),
    .dev_o      (dev),
    .trdy_o     (trdy),
    .stop_o     (stop),
    .oe_o       (oe),
    .xfer_o     (xfer),
    .latch_o    (latch),
    .in_data_o  (in_data),
    .load_o     (load)
  );

  pci_tgt_dpath #(.DW(DW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_i    (latch),
    .rd_i       (dec_rd),
    .xfer_i     (xfer),
    .load_i     (load),
    .in_data_i  (in_data),
    .ad_i       (ad_i),
    .cbe_ni     (cbe_ni),
    .be_rdata_i (be_rdata_i),
    .be_addr_o  (be_addr_o),
    .rd_o       (rd_q),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe_o),
    .par_o      (par_o),
    .par_oe_o   (par_oe_o)
  );

  pci_tgt_strap #(.W(STRAP_W + 1)) u_strap (
    .rst_ni (rst_ni),
    .pins_i ({strap_swap_i, strap_mode_i}),
    .cfg_o  (strap_o)
  );

  assign devsel_no   = ~dev;
  assign trdy_no     = ~trdy;
  assign stop_no     = ~stop;
  assign devsel_oe_o = oe;
  assign trdy_oe_o   = oe;
  assign stop_oe_o   = oe;
  assign be_ack_o    = xfer;
  assign be_we_o     = ~rd_q;
  assign be_wdata_o  = ad_i;
  assign be_strb_o   = ~cbe_ni;
endmodule

// File: rtl/pci_tgt_ctrl_chk.sv
module pci_tgt_ctrl_chk #(
  parameter int DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_ni,
  input logic            irdy_ni,
  input logic            trdy_no,
  input logic            trdy_oe_o,
  input logic            devsel_no,
  input logic            devsel_oe_o,
  input logic            stop_no,
  input logic            stop_oe_o,
  input logic [DW-1:0]   ad_o,
  input logic            ad_oe_o,
  input logic [DW/8-1:0] cbe_ni,
  input logic            par_o,
  input logic            par_oe_o,
  input logic            be_ack_o
);
  assert_ack_needs_both_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_ack_o |-> (trdy_oe_o && !trdy_no && !irdy_ni));

  assert_devsel_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (devsel_oe_o && $rose(devsel_no)) |=> !devsel_oe_o);

  assert_trdy_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_oe_o && !trdy_no && irdy_ni) |=> (trdy_oe_o && !trdy_no));

  assert_no_trdy_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_oe_o && !stop_no && trdy_no) |=> trdy_no);

  assert_stop_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_oe_o && !stop_no && !(frame_ni && !irdy_ni)) |=> !stop_no);

  assert_par_even_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> (par_o == ^$past({ad_o, cbe_ni})));

  assert_par_follows_ad_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ad_oe_o) |=> !par_oe_o);
endmodule

bind pci_tgt_ctrl pci_tgt_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_pci_tgt_ctrl.sv
module tb_pci_tgt_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b1, irdy_ni = 1'b1;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_ni = 4'hF;
  logic [31:0] base_i = 32'h4000_0000, mask_i = 32'hFFFF_F000;
  logic        retry_i = 1'b0, term_req_i = 1'b0, be_ready_i = 1'b0;
  logic [31:0] be_rdata_i;
  logic [17:0] strap_mode_i = 18'h2A5C3;
  logic        strap_swap_i = 1'b1;
  logic        devsel_no, devsel_oe_o, trdy_no, trdy_oe_o, stop_no, stop_oe_o;
  logic [31:0] ad_o, be_addr_o, be_wdata_o;
  logic        ad_oe_o, par_o, par_oe_o, be_we_o, be_ack_o;
  logic [3:0]  be_strb_o;
  logic [18:0] strap_o;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  function automatic logic [31:0] rd_fn(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
  endfunction

  assign be_rdata_i = rd_fn(be_addr_o);

  pci_tgt_ctrl dut (.*);

  // behavioural reference: 0 idle, 1 data, 2 release, 3 ignore
  int          m_ph;
  bit          m_rd, m_trdy, m_stop, m_dev, m_oe, m_adoe, m_par, m_paroe, m_xf;
  logic [31:0] m_addr, m_ad;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_rd = 0; m_trdy = 0; m_stop = 0; m_dev = 0; m_oe = 0;
      m_adoe = 0; m_par = 0; m_paroe = 0; m_xf = 0; m_addr = '0; m_ad = '0;
    end else begin
      bit npar, npoe, done, shake, ntr;
      npar = ^{m_ad, cbe_ni};
      npoe = m_adoe;
      m_xf = 0;
      case (m_ph)
        0: begin
          m_adoe = 0;
          if (!frame_ni) begin
            if ((((ad_i ^ base_i) & mask_i) == 0) && (cbe_ni == 4'b0110 || cbe_ni == 4'b0111)) begin
              m_ph = 1; m_rd = (cbe_ni == 4'b0110); m_addr = ad_i;
              m_dev = 1; m_oe = 1; m_trdy = 0; m_stop = 0;
            end else m_ph = 3;
          end
        end
        1: begin
          m_xf  = m_trdy && !irdy_ni;
          shake = m_stop && !irdy_ni;
          done  = frame_ni && (m_xf || shake);
          if (m_xf) m_addr = m_addr + 4;
          if (done) begin
            m_ph = 2; m_dev = 0; m_trdy = 0; m_stop = 0; m_adoe = 0;
          end else begin
            m_adoe = m_rd;
            if (!(m_trdy && irdy_ni)) begin
              if (m_stop) ntr = 0;
              else if (term_req_i) begin
                if (retry_i) begin m_stop = 1; ntr = 0; end
                else begin ntr = be_ready_i; m_stop = be_ready_i; end
              end else ntr = be_ready_i;
              if (ntr && m_rd) m_ad = rd_fn(m_addr);
              m_trdy = ntr;
            end
          end
        end
        2: begin m_ph = 0; m_oe = 0; end
        default: if (frame_ni && irdy_ni) m_ph = 0;
      endcase
      m_par = npar;
      m_paroe = npoe;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all();
    bit ack_exp;
    ack_exp = (m_ph == 1) && m_trdy && !irdy_ni;
    chk("R3 devsel_oe", 32'(devsel_oe_o), 32'(m_oe));
    chk("R10 trdy_oe", 32'(trdy_oe_o), 32'(m_oe));
    chk("R10 stop_oe", 32'(stop_oe_o), 32'(m_oe));
    if (m_oe) begin
      chk("R3 devsel", 32'(devsel_no), 32'(!m_dev));
      chk("R4 trdy", 32'(trdy_no), 32'(!m_trdy));
      chk("R7 stop", 32'(stop_no), 32'(!m_stop));
    end
    chk("R8 ad_oe", 32'(ad_oe_o), 32'(m_adoe));
    if (m_adoe) chk("R8 ad", ad_o, m_ad);
    chk("R9 par_oe", 32'(par_oe_o), 32'(m_paroe));
    if (m_paroe) chk("R9 par", 32'(par_o), 32'(m_par));
    chk("R2 ack", 32'(be_ack_o), 32'(ack_exp));
    if (m_ph == 1) chk("R2 addr", be_addr_o, ack_exp ? m_addr + 4 : m_addr);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      frame_ni = 1; irdy_ni = 1; term_req_i = 0; cbe_ni = 4'hF;
      #1 chk_all();
    end
  endtask

  // master: nph phases, dly initial IRDY# wait clocks, pat back-end ready pattern
  task automatic bus_cycle(input logic [31:0] a, input logic [3:0] cmd, input int nph,
                           input int dly, input logic [7:0] pat, input int term_after,
                           input bit rty);
    int rem, nx, d;
    rem = nph; nx = 0; d = dly;
    retry_i = rty;
    @(negedge clk_i);
    frame_ni = 0; irdy_ni = 1; ad_i = a; cbe_ni = cmd; be_ready_i = pat[0]; term_req_i = 0;
    #1 chk_all();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_i);
      if (m_xf) begin rem--; nx++; end
      if (m_ph == 0 || m_ph == 2) begin
        frame_ni = 1; irdy_ni = 1; term_req_i = 0; cbe_ni = 4'hF;
        #1 chk_all();
        break;
      end
      if (m_ph == 3) begin
        frame_ni = 1; irdy_ni = (k == 0) ? 1'b0 : 1'b1; cbe_ni = 4'h0;
      end else begin
        cbe_ni = 4'h0;
        ad_i = a ^ (32'h0101_0101 * k);
        irdy_ni = (d > 0);
        if (d > 0) d--;
        if (!irdy_ni && (rem <= 1 || m_stop)) frame_ni = 1;
        be_ready_i = pat[k % 8];
        term_req_i = (term_after >= 0) && (nx >= term_after);
      end
      #1 chk_all();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12: all enables low during reset
    chk("R12 devsel_oe", 32'(devsel_oe_o), 0);
    chk("R12 trdy_oe", 32'(trdy_oe_o), 0);
    chk("R12 stop_oe", 32'(stop_oe_o), 0);
    chk("R12 ad_oe", 32'(ad_oe_o), 0);
    chk("R12 par_oe", 32'(par_oe_o), 0);
    #5 rst_ni = 1'b1;
    #2;
    chk("R11 strap", 32'(strap_o), {13'd0, 1'b1, 18'h2A5C3});
    strap_mode_i = 18'h15A3C; strap_swap_i = 1'b0;
    idle(2);
    chk("R11 strap hold", 32'(strap_o), {13'd0, 1'b1, 18'h2A5C3});

    // R1 R2 R3 R4: single write and write burst with ready gaps
    bus_cycle(32'h4000_0010, 4'b0111, 1, 0, 8'hFF, -1, 0);
    idle(2);
    bus_cycle(32'h4000_0200, 4'b0111, 3, 0, 8'h5A, -1, 0);
    idle(2);
    // R8 R9: read bursts, with IRDY# waits holding TRDY# (R4)
    bus_cycle(32'h4000_0100, 4'b0110, 3, 2, 8'hB6, -1, 0);
    idle(2);
    bus_cycle(32'h4000_0F00, 4'b0110, 4, 0, 8'hFF, -1, 0);
    idle(2);
    // R10: just outside the window, then a non-memory command inside it
    bus_cycle(32'h4000_1000, 4'b0110, 2, 0, 8'hFF, -1, 0);
    idle(2);
    bus_cycle(32'h4000_0040, 4'b0010, 2, 0, 8'hFF, -1, 0);
    idle(2);
    // R5: disconnect after the first transfer, and on a gapped ready
    bus_cycle(32'h4000_0300, 4'b0110, 4, 0, 8'hFF, 1, 0);
    idle(2);
    bus_cycle(32'h4000_0400, 4'b0111, 5, 1, 8'hA5, 2, 0);
    idle(2);
    // R6: retry before any data, and retry after one transfer
    bus_cycle(32'h4000_0500, 4'b0111, 2, 0, 8'hFF, 0, 1);
    idle(2);
    bus_cycle(32'h4000_0600, 4'b0110, 3, 0, 8'hFF, 1, 1);
    idle(3);
    chk("R11 strap end", 32'(strap_o), {13'd0, 1'b1, 18'h2A5C3});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule